// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks a clock generator through the safe procedure for changing its feedback multiplier and reference pre-divider, so that software issues one request instead of stepping through each stage by hand. A request carries the new multiplier and divider codes. The sequencer first drops the downstream clocks onto the bypass path. It then holds the PLL in reset and loads the new codes. It keeps reset asserted for a fixed number of reference cycles, releases it, and waits for the lock indication before routing the PLL output back to the clock tree.

A multiplier code outside the supported range is refused at the request, and nothing at the PLL side moves. If lock does not appear within a bounded window, the clocks stay on bypass and an error is reported with its cause. The hold time and the lock window are parameters counted in reference clock cycles. All outputs are registered.

Top module: `pll_reseq`

## Requirements
- R1: After synchronous reset `pll_en_o` is 0, `pll_rst_o` is 1, `mult_o` and `div_o` hold their reset codes (0 by default), and `busy_o`, `done_o` and `err_o` are 0.
- R2: An accepted request (`start_i` high while idle with a valid code) sets `busy_o` to 1 and `pll_en_o` to 0 at that edge. `pll_rst_o` is 1 from the next edge, while `pll_en_o` is still 0.
- R3: The new codes appear on `mult_o` and `div_o` one edge after `pll_rst_o` is asserted. They never change while `pll_rst_o` is 0.
- R4: `pll_rst_o` stays 1 for exactly HOLD_CYCLES cycles with the new codes applied, then drops to 0 while `pll_en_o` stays 0.
- R5: After release, `pll_en_o` rises at the first edge that samples `lock_i` high. At that edge `done_o` pulses for one cycle and `busy_o` falls. `lock_i` has no effect before reset is released.
- R6: If `lock_i` is not sampled high in the LOCK_TIMEOUT cycles after release, `err_o` pulses with `err_cause_o` = 1, `busy_o` falls, and `pll_en_o` stays 0. A lock sampled in the last cycle of that window counts as success.
- R7: `start_i` is ignored while `busy_o` is 1. The codes presented with it are never applied, and no second sequence follows.
- R8: A multiplier code below 2 or above 15 makes `err_o` pulse with `err_cause_o` = 0 one edge after the request. `busy_o` stays 0 and `pll_en_o`, `pll_rst_o`, `mult_o` and `div_o` keep their values. Every divider code (0 to 31, ratio = code + 1) is valid.
- R9: `done_o` and `err_o` are one-cycle pulses that are never high together, and `busy_o` only falls in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Reprogramming request |
| mult_i | input | MULT_W | Requested multiplier code |
| div_i | input | DIV_W | Requested pre-divider code (ratio = code + 1) |
| lock_i | input | 1 | Lock indication from the PLL |
| pll_en_o | output | 1 | 1 selects the PLL output, 0 selects bypass |
| pll_rst_o | output | 1 | PLL reset, active high |
| mult_o | output | MULT_W | Multiplier code applied to the PLL |
| div_o | output | DIV_W | Pre-divider code applied to the PLL |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: sequence completed with lock |
| err_o | output | 1 | One-cycle pulse: request refused or lock timed out |
| err_cause_o | output | 1 | 0 = reserved multiplier code, 1 = lock timeout |

## Verification
The lock-wait state can see a lock and reach the end of its timeout window in the same cycle. The bench provokes this by holding `lock_i` low for LOCK_TIMEOUT-1 sampled edges after release, then raising it so that it is first sampled on the very edge where the timeout would fire. In that cycle the result must be a success: `pll_en_o` at 1 and `done_o` high, with `err_o` low. The bench sets this against a run where lock never arrives, which must end in the timeout error with the clocks still on bypass.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_BYPASS     = 3'd1,
    ST_ASSERT_RST = 3'd2,
    ST_HOLD       = 3'd3,
    ST_WAIT_LOCK  = 3'd4
  } seq_state_t;

  localparam logic CAUSE_BAD_CODE = 1'b0;
  localparam logic CAUSE_TIMEOUT  = 1'b1;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pll_reseq_codechk.sv
module pll_reseq_codechk #(
  parameter int unsigned MULT_W   = 5,
  parameter int unsigned MULT_MIN = 2,
  parameter int unsigned MULT_MAX = 15
) (
  input  logic [MULT_W-1:0] mult_i,
  output logic              ok_o
);

  localparam logic [MULT_W-1:0] LO = MULT_W'(MULT_MIN);
  localparam logic [MULT_W-1:0] HI = MULT_W'(MULT_MAX);

  assign ok_o = (mult_i >= LO) && (mult_i <= HI);

endmodule

// File: rtl/pll_reseq_cnt.sv
module pll_reseq_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/pll_reseq_fsm.sv
module pll_reseq_fsm
  import pll_reseq_pkg::*;
#(
  parameter int unsigned MULT_W       = 5,
  parameter int unsigned DIV_W        = 5,
  parameter int unsigned CNT_W        = 12,
  parameter int unsigned HOLD_CYCLES  = 25,
  parameter int unsigned LOCK_TIMEOUT = 4000,
  parameter int unsigned MULT_RST     = 0,
  parameter int unsigned DIV_RST      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              code_ok_i,
  input  logic              lock_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic              pll_en_o,
  output logic              pll_rst_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_cause_o
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TIMEOUT - 1);

  seq_state_t        state;
  logic [MULT_W-1:0] mult_sh;
  logic [DIV_W-1:0]  div_sh;
  logic              hold_end;
  logic              wait_end;

  assign hold_end = (state == ST_HOLD) && (cnt_i == HOLD_LAST);
  assign wait_end = (state == ST_WAIT_LOCK) && (cnt_i == LOCK_LAST);

  // The shared counter runs only in the two timed states and restarts at
  // the hand-over from hold to lock wait.
  always_comb begin
    cnt_clr_o = 1'b1;
    cnt_inc_o = 1'b0;
    if (state == ST_HOLD) begin
      cnt_clr_o = hold_end;
      cnt_inc_o = !hold_end;
    end else if (state == ST_WAIT_LOCK) begin
      cnt_clr_o = 1'b0;
      cnt_inc_o = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pll_en_o    <= 1'b0;
      pll_rst_o   <= 1'b1;
      mult_o      <= MULT_W'(MULT_RST);
      div_o       <= DIV_W'(DIV_RST);
      mult_sh     <= MULT_W'(MULT_RST);
      div_sh      <= DIV_W'(DIV_RST);
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      err_cause_o <= CAUSE_BAD_CODE;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            if (code_ok_i) begin
              mult_sh  <= mult_i;
              div_sh   <= div_i;
              busy_o   <= 1'b1;
              pll_en_o <= 1'b0;
              state    <= ST_BYPASS;
            end else begin
              err_o       <= 1'b1;
              err_cause_o <= CAUSE_BAD_CODE;
            end
          end
        end
        ST_BYPASS: begin
          pll_rst_o <= 1'b1;
          state     <= ST_ASSERT_RST;
        end
        ST_ASSERT_RST: begin
          mult_o <= mult_sh;
          div_o  <= div_sh;
          state  <= ST_HOLD;
        end
        ST_HOLD: begin
          if (hold_end) begin
            pll_rst_o <= 1'b0;
            state     <= ST_WAIT_LOCK;
          end
        end
        ST_WAIT_LOCK: begin
          if (lock_i) begin
            pll_en_o <= 1'b1;
            busy_o   <= 1'b0;
            done_o   <= 1'b1;
            state    <= ST_IDLE;
          end else if (wait_end) begin
            busy_o      <= 1'b0;
            err_o       <= 1'b1;
            err_cause_o <= CAUSE_TIMEOUT;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RST_AFTER_BYPASS: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_rst_o) |-> (!pll_en_o && !$past(pll_en_o))); // R2

  AST_CFG_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mult_o) || !$stable(div_o)) |-> (pll_rst_o && $past(pll_rst_o))); // R3

  AST_EN_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_o) |-> ($past(lock_i) && !pll_rst_o && done_o)); // R5

  AST_TIMEOUT_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (err_o && err_cause_o == CAUSE_TIMEOUT) |-> (!pll_en_o && !pll_rst_o)); // R6

  AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (err_o && err_cause_o == CAUSE_BAD_CODE) |->
      ($stable(pll_en_o) && $stable(pll_rst_o) && $stable(mult_o) && $stable(div_o) && !busy_o)); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done_o && err_o)); // R9

  AST_BUSY_ENDS_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || err_o)); // R9

endmodule

// File: rtl/pll_reseq.sv
module pll_reseq
  import pll_reseq_pkg::*;
#(
  parameter int unsigned MULT_W       = 5,
  parameter int unsigned DIV_W        = 5,
  parameter int unsigned MULT_MIN     = 2,
  parameter int unsigned MULT_MAX     = 15,
  parameter int unsigned HOLD_CYCLES  = 25,
  parameter int unsigned LOCK_TIMEOUT = 4000,
  parameter int unsigned MULT_RST     = 0,
  parameter int unsigned DIV_RST      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic              pll_rst_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              err_cause_o
);

  localparam int unsigned CNT_W = $clog2(max_u(HOLD_CYCLES, LOCK_TIMEOUT) + 1);

  logic             code_ok;
  logic             cnt_clr;
  logic             cnt_inc;
  logic [CNT_W-1:0] cnt;

  pll_reseq_codechk #(
    .MULT_W  (MULT_W),
    .MULT_MIN(MULT_MIN),
    .MULT_MAX(MULT_MAX)
  ) u_codechk (
    .mult_i(mult_i),
    .ok_o  (code_ok)
  );

  pll_reseq_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr_i(cnt_clr),
    .inc_i(cnt_inc),
    .cnt_o(cnt)
  );

  pll_reseq_fsm #(
    .MULT_W      (MULT_W),
    .DIV_W       (DIV_W),
    .CNT_W       (CNT_W),
    .HOLD_CYCLES (HOLD_CYCLES),
    .LOCK_TIMEOUT(LOCK_TIMEOUT),
    .MULT_RST    (MULT_RST),
    .DIV_RST     (DIV_RST)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mult_i     (mult_i),
    .div_i      (div_i),
    .code_ok_i  (code_ok),
    .lock_i     (lock_i),
    .cnt_i      (cnt),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .pll_en_o   (pll_en_o),
    .pll_rst_o  (pll_rst_o),
    .mult_o     (mult_o),
    .div_o      (div_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_cause_o(err_cause_o)
  );

  // Independent hold-time monitor: counts cycles with reset high since the
  // applied codes last changed, saturating at the required hold.
  localparam logic [CNT_W-1:0] HOLD_SAT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0]  mon_hold;
  logic [MULT_W-1:0] mon_mult;
  logic [DIV_W-1:0]  mon_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_hold <= '0;
      mon_mult <= MULT_W'(MULT_RST);
      mon_div  <= DIV_W'(DIV_RST);
    end else begin
      mon_mult <= mult_o;
      mon_div  <= div_o;
      if (!pll_rst_o) begin
        mon_hold <= '0;
      end else if ((mult_o != mon_mult) || (div_o != mon_div)) begin
        mon_hold <= CNT_W'(1);
      end else if (mon_hold != HOLD_SAT) begin
        mon_hold <= mon_hold + 1'b1;
      end
    end
  end

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst_o) |-> (mon_hold >= HOLD_SAT)); // R4

endmodule

// File: tb/test_pll_reseq.sv
module test_pll_reseq;

  localparam int unsigned MULT_W  = 5;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned HOLD    = 6;
  localparam int unsigned TIMEOUT = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [MULT_W-1:0] mult_i = '0;
  logic [DIV_W-1:0]  div_i = '0;
  logic              lock_i = 1'b0;
  logic              pll_en_o, pll_rst_o, busy_o, done_o, err_o, err_cause_o;
  logic [MULT_W-1:0] mult_o;
  logic [DIV_W-1:0]  div_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  pll_reseq #(
    .MULT_W(MULT_W), .DIV_W(DIV_W), .HOLD_CYCLES(HOLD), .LOCK_TIMEOUT(TIMEOUT)
  ) i_pll_reseq (
    .clk(clk), .rst(rst), .start_i(start_i), .mult_i(mult_i), .div_i(div_i),
    .lock_i(lock_i), .pll_en_o(pll_en_o), .pll_rst_o(pll_rst_o),
    .mult_o(mult_o), .div_o(div_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .err_cause_o(err_cause_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Request, bypass, reset, apply, hold, release; returns after the release edge.
  task automatic seq_to_release(input int m, input int d);
    int old_m = int'(mult_o);
    int old_d = int'(div_o);
    start_i = 1'b1; mult_i = MULT_W'(m); div_i = DIV_W'(d);
    step();
    start_i = 1'b0;
    check("R2", "busy after request", int'(busy_o), 1);
    check("R2", "bypass after request", int'(pll_en_o), 0);
    check("R3", "mult not yet applied", int'(mult_o), old_m);
    step();
    check("R2", "reset asserted", int'(pll_rst_o), 1);
    check("R2", "still bypass in reset", int'(pll_en_o), 0);
    check("R3", "div not yet applied", int'(div_o), old_d);
    step();
    check("R3", "mult applied", int'(mult_o), m);
    check("R3", "div applied", int'(div_o), d);
    check("R4", "reset high at apply", int'(pll_rst_o), 1);
    for (int i = 1; i < HOLD; i++) begin
      step();
      check("R4", "reset held", int'(pll_rst_o), 1);
      check("R5", "no enable during hold", int'(pll_en_o), 0);
    end
    step();
    check("R4", "reset released after hold", int'(pll_rst_o), 0);
    check("R4", "bypass at release", int'(pll_en_o), 0);
    check("R9", "busy at release", int'(busy_o), 1);
  endtask

  task automatic lock_after(input int j);
    lock_i = 1'b0;
    for (int i = 1; i < j; i++) begin
      step();
      check("R5", "waiting, no enable", int'(pll_en_o), 0);
      check("R6", "waiting, no error", int'(err_o), 0);
    end
    lock_i = 1'b1;
    step();
    check("R5", "enable on lock", int'(pll_en_o), 1);
    check("R5", "done pulse", int'(done_o), 1);
    check("R9", "busy drops", int'(busy_o), 0);
    check("R9", "no error with done", int'(err_o), 0);
    step();
    check("R9", "done is one cycle", int'(done_o), 0);
    lock_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "pll_en reset", int'(pll_en_o), 0);
    check("R1", "pll_rst reset", int'(pll_rst_o), 1);
    check("R1", "mult reset", int'(mult_o), 0);
    check("R1", "div reset", int'(div_o), 0);
    check("R1", "busy reset", int'(busy_o), 0);
    check("R1", "done reset", int'(done_o), 0);
    check("R1", "err reset", int'(err_o), 0);
  endtask

  task automatic t_basic();
    seq_to_release(5, 3);
    lock_after(4);
  endtask

  task automatic t_code_edges();
    seq_to_release(15, 31);
    lock_after(1);
    seq_to_release(2, 0);
    lock_after(2);
  endtask

  task automatic t_early_lock();
    lock_i = 1'b1;
    seq_to_release(7, 1);
    step();
    check("R5", "enable one edge after release", int'(pll_en_o), 1);
    check("R5", "done with early lock", int'(done_o), 1);
    lock_i = 1'b0;
    step();
  endtask

  task automatic t_timeout();
    seq_to_release(9, 4);
    lock_i = 1'b0;
    for (int i = 1; i < TIMEOUT; i++) step();
    check("R6", "no error before window end", int'(err_o), 0);
    check("R6", "busy before window end", int'(busy_o), 1);
    step();
    check("R6", "timeout error", int'(err_o), 1);
    check("R6", "timeout cause", int'(err_cause_o), 1);
    check("R6", "bypass kept", int'(pll_en_o), 0);
    check("R6", "busy dropped", int'(busy_o), 0);
    check("R9", "no done with error", int'(done_o), 0);
    step();
    check("R9", "error is one cycle", int'(err_o), 0);
    check("R6", "still bypass", int'(pll_en_o), 0);
  endtask

  task automatic t_lock_at_limit();
    seq_to_release(6, 2);
    lock_after(TIMEOUT);
  endtask

  task automatic t_start_while_busy();
    seq_to_release(4, 8);
    start_i = 1'b1; mult_i = 5'd9; div_i = 5'd17;
    step();
    step();
    start_i = 1'b0;
    lock_after(2);
    check("R7", "mult from busy request ignored", int'(mult_o), 4);
    check("R7", "div from busy request ignored", int'(div_o), 8);
    for (int i = 0; i < 4; i++) step();
    check("R7", "no second sequence", int'(busy_o), 0);
    check("R7", "enable kept", int'(pll_en_o), 1);
    check("R7", "mult still kept", int'(mult_o), 4);
  endtask

  task automatic t_reject(input int m);
    int m0 = int'(mult_o);
    int d0 = int'(div_o);
    int e0 = int'(pll_en_o);
    int r0 = int'(pll_rst_o);
    start_i = 1'b1; mult_i = MULT_W'(m); div_i = 5'd5;
    step();
    start_i = 1'b0;
    check("R8", "reject error", int'(err_o), 1);
    check("R8", "reject cause", int'(err_cause_o), 0);
    check("R8", "reject not busy", int'(busy_o), 0);
    check("R8", "reject keeps enable", int'(pll_en_o), e0);
    check("R8", "reject keeps reset", int'(pll_rst_o), r0);
    check("R8", "reject keeps mult", int'(mult_o), m0);
    check("R8", "reject keeps div", int'(div_o), d0);
    step();
    check("R8", "reject pulse ends", int'(err_o), 0);
    check("R8", "still not busy", int'(busy_o), 0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst = 1'b0;
    step();
    t_reject(1);
    t_basic();
    t_reject(0);
    t_reject(16);
    t_reject(31);
    t_code_edges();
    t_early_lock();
    t_timeout();
    t_lock_at_limit();
    t_start_while_busy();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule